// File: doc/BRIEF.md
# Percentile-Clipped Auto White Balance

This block balances the colours of a streaming 8-bit RGB image by stretching each channel on its own. While a frame streams through, it counts how often every level appears in the red, green and blue channels. Once the frame's last pixel has arrived, it walks those counts to find a low and a high level per channel. A programmable percentage of the darkest and of the brightest pixels is left out of that search, so a few outliers cannot pin the range. From the start of the next frame, each channel value is mapped linearly so that the clipped range covers the whole 0..255 output scale.

Two histogram banks take turns. One bank collects the frame that is arriving. The other is scanned and then cleared. Pixels travel as a valid-qualified stream with start-of-frame and end-of-frame markers. A mode input selects either the correction or a plain pass-through. Both paths have the same latency, so changing the mode never shifts a frame in time.

Top module: `awb_top`

## Requirements
- R1: After reset, out_valid is 0. Until statistics from a complete frame are available, every pixel leaves unchanged. After a reset in mid-run, no statistics gathered before that reset are used.
- R2: Every accepted input pixel (in_valid=1) appears on the outputs exactly 2 clock cycles later, with out_sof and out_eof equal to its in_sof and in_eof. No other cycle has out_valid=1. This holds in both modes.
- R3: Correction is applied only to pixels presented with mode equal to 1. With any other mode value, out_r/out_g/out_b equal the pixel's input values.
- R4: The clip count for a frame is floor(N*P/100). N is the number of valid pixels from the in_sof pixel up to and including the in_eof pixel. P is the clip_pct value presented with the in_eof pixel. clip_pct on the frame's other pixels has no effect.
- R5: For each channel separately: lo is the smallest level v for which the count of pixels with level ≤ v exceeds the clip count, or 255 if there is none. hi is the largest level v for which the count of pixels with level ≥ v exceeds the clip count, or 0 if there is none.
- R6: With valid statistics and hi > lo, a corrected channel value is 0 for x ≤ lo, 255 for x ≥ hi, and floor((x-lo)*255/(hi-lo)) in between.
- R7: For a channel whose hi ≤ lo (a flat channel, or a clip share of half or more), the channel value passes through unchanged.
- R8: The statistics of a frame apply to every pixel of the next frame, starting with its in_sof pixel. This requires at least 520 idle cycles between a frame's in_eof pixel and the next in_sof pixel. The values stay fixed for the whole frame.
- R9: Each frame's statistics come only from that frame's own pixels. The bank just used is cleared while the other bank collects the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 8 | 1 = correction on; any other value = pass-through |
| clip_pct | input | 7 | Percentage of pixels dropped at each end of a channel's distribution; sampled with the eof pixel |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | First pixel of a frame |
| in_eof | input | 1 | Last pixel of a frame |
| in_r | input | 8 | Red input level |
| in_g | input | 8 | Green input level |
| in_b | input | 8 | Blue input level |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | First pixel of a frame, delayed |
| out_eof | output | 1 | Last pixel of a frame, delayed |
| out_r | output | 8 | Red output level |
| out_g | output | 8 | Green output level |
| out_b | output | 8 | Blue output level |

## Verification
Most frames are rotated ramps of 100 distinct levels, offset per channel. Different offsets, rotations and clip shares make lo and hi move by known amounts, so an error in the cumulative walk or in the stretch arithmetic shows up as a wrong level. A constant frame and clip shares of 50 and 100 percent force hi ≤ lo and tell the bypass apart from the arithmetic. A 37-pixel frame whose clip count needs flooring checks the pixel count and the rounding. Each frame changes clip_pct on its non-final pixels, so sampling it at the wrong moment is caught. Back-to-back frames with shifted offsets would expose a bank that was not cleared.

// File: rtl/awb_pkg.sv
package awb_pkg;
  localparam int NCH = 3;

  typedef enum logic [2:0] {
    EV_INIT,
    EV_IDLE,
    EV_UP,
    EV_DOWN,
    EV_DONE
  } ev_state_e;
endpackage

// File: rtl/awb_hist_bank.sv
// Two histograms for one channel: one counts incoming levels, the other is scanned and cleared.
module awb_hist_bank #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             init_clr,
  input  logic             coll_sel,
  input  logic             inc_en,
  input  logic [PIX_W-1:0] inc_idx,
  input  logic [PIX_W-1:0] scan_idx,
  input  logic             scan_clr,
  output logic [CNT_W-1:0] scan_bin
);
  localparam int BINS = 1 << PIX_W;

  logic [CNT_W-1:0] rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [CNT_W-1:0] mem [BINS];
    logic             is_coll;
    logic [CNT_W-1:0] cur;

    assign is_coll = (coll_sel == (b == 1));
    assign cur     = mem[inc_idx];

    always_ff @(posedge clk) begin
      if (init_clr)
        mem[scan_idx] <= '0;
      else if (!is_coll && scan_clr)
        mem[scan_idx] <= '0;
      else if (is_coll && inc_en && (cur != '1))
        mem[inc_idx] <= cur + 1'b1;
    end

    assign rd[b] = mem[scan_idx];
  end

  // The bank under evaluation is the one not collecting.
  assign scan_bin = coll_sel ? rd[0] : rd[1];
endmodule

// File: rtl/awb_range_find.sv
// Walks one channel's histogram upward for the low level, then downward for the high level.
module awb_range_find #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 16,
  parameter int SW    = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             last,
  input  logic [PIX_W-1:0] idx,
  input  logic [CNT_W-1:0] bin,
  input  logic [SW-1:0]    clip,
  output logic [PIX_W-1:0] lo,
  output logic [PIX_W-1:0] hi
);
  logic [SW-1:0] cum, sum;
  logic          lo_f, hi_f;

  assign sum = cum + SW'(bin);

  always_ff @(posedge clk) begin
    if (rst) begin
      cum  <= '0;
      lo   <= '1;
      hi   <= '0;
      lo_f <= 1'b0;
      hi_f <= 1'b0;
    end else begin
      if (restart) begin
        lo   <= '1;
        hi   <= '0;
        lo_f <= 1'b0;
        hi_f <= 1'b0;
      end
      if (step_up && !lo_f && (sum > clip)) begin
        lo   <= idx;
        lo_f <= 1'b1;
      end
      if (step_dn && !hi_f && (sum > clip)) begin
        hi   <= idx;
        hi_f <= 1'b1;
      end
      if (restart || last)
        cum <= '0;
      else if (step_up || step_dn)
        cum <= sum;
    end
  end
endmodule

// File: rtl/awb_stretch.sv
// Two-stage linear stretch of one channel level; the bypass path keeps the same depth.
module awb_stretch #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic [PIX_W-1:0] x,
  input  logic [PIX_W-1:0] lo,
  input  logic [PIX_W-1:0] hi,
  input  logic             bypass,
  output logic [PIX_W-1:0] y
);
  localparam int              PW   = 2 * PIX_W;
  localparam logic [PIX_W-1:0] FULL = '1;

  logic [PIX_W-1:0] x_r, d_r, span_r;
  logic             byp_r, top_r;
  logic [PW-1:0]    q;

  always_ff @(posedge clk) begin
    x_r    <= x;
    byp_r  <= bypass;
    top_r  <= (x >= hi);
    d_r    <= (x > lo) ? x - lo : '0;
    span_r <= (hi > lo) ? hi - lo : PIX_W'(1);
  end

  assign q = (PW'(d_r) * PW'(FULL)) / PW'(span_r);

  always_ff @(posedge clk) begin
    if (byp_r)      y <= x_r;
    else if (top_r) y <= FULL;
    else            y <= PIX_W'(q);
  end
endmodule

// File: rtl/awb_top.sv
module awb_top
  import awb_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int CNT_W  = 16,
  parameter int PCT_W  = 7,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic [PCT_W-1:0]  clip_pct,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  localparam int               BINS    = 1 << PIX_W;
  localparam logic [PIX_W-1:0] TOP_BIN = PIX_W'(BINS - 1);
  localparam int               SW      = CNT_W + PIX_W + PCT_W;

  logic [PIX_W-1:0] pix  [NCH];
  logic [PIX_W-1:0] outp [NCH];
  logic [CNT_W-1:0] bin  [NCH];
  logic [PIX_W-1:0] fl_lo [NCH], fl_hi [NCH];
  logic [PIX_W-1:0] res_lo [NCH], res_hi [NCH];
  logic [PIX_W-1:0] app_lo [NCH], app_hi [NCH];
  logic [PIX_W-1:0] eff_lo [NCH], eff_hi [NCH];
  logic             byp [NCH];

  assign pix[0] = in_r;
  assign pix[1] = in_g;
  assign pix[2] = in_b;

  logic fire, sop, eop;
  assign fire = in_valid;
  assign sop  = in_valid && in_sof;
  assign eop  = in_valid && in_eof;

  ev_state_e        st;
  logic [PIX_W-1:0] idx;
  logic             coll_sel;
  logic [CNT_W-1:0] cnt, cnt_now, tot_r;
  logic [PCT_W-1:0] pct_r;
  logic [SW-1:0]    clip;
  logic             res_ok, app_ok, eff_ok;
  logic             init_clr, inc_en, scan_up, scan_dn, scan_last, restart, mode_on;

  always_comb begin
    if (sop)              cnt_now = CNT_W'(1);
    else if (cnt == '1)   cnt_now = cnt;
    else                  cnt_now = cnt + 1'b1;
  end

  assign clip      = (SW'(tot_r) * SW'(pct_r)) / SW'(100);
  assign init_clr  = (st == EV_INIT);
  assign inc_en    = fire && (st != EV_INIT);
  assign scan_up   = (st == EV_UP);
  assign scan_dn   = (st == EV_DOWN);
  assign scan_last = (scan_up && idx == TOP_BIN) || (scan_dn && idx == '0);
  assign restart   = (st == EV_IDLE) && eop;
  assign mode_on   = (mode == MODE_W'(1));

  // Frame bookkeeping and the evaluation sequencer.
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= EV_INIT;
      idx      <= '0;
      coll_sel <= 1'b0;
      cnt      <= '0;
      tot_r    <= '0;
      pct_r    <= '0;
      res_ok   <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        res_lo[c] <= '0;
        res_hi[c] <= '0;
      end
    end else begin
      if (fire) cnt <= cnt_now;
      case (st)
        EV_INIT: begin
          idx <= idx + 1'b1;
          if (idx == TOP_BIN) st <= EV_IDLE;
        end
        EV_IDLE: if (eop) begin
          st       <= EV_UP;
          idx      <= '0;
          coll_sel <= ~coll_sel;
          tot_r    <= cnt_now;
          pct_r    <= clip_pct;
        end
        EV_UP: begin
          if (idx == TOP_BIN) st <= EV_DOWN;
          else                idx <= idx + 1'b1;
        end
        EV_DOWN: begin
          if (idx == '0) st <= EV_DONE;
          else           idx <= idx - 1'b1;
        end
        EV_DONE: begin
          st     <= EV_IDLE;
          res_ok <= 1'b1;
          for (int c = 0; c < NCH; c++) begin
            res_lo[c] <= fl_lo[c];
            res_hi[c] <= fl_hi[c];
          end
        end
        default: st <= EV_IDLE;
      endcase
    end
  end

  // Parameters in force for the frame, taken at its first pixel.
  always_ff @(posedge clk) begin
    if (rst) begin
      app_ok <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        app_lo[c] <= '0;
        app_hi[c] <= '0;
      end
    end else if (sop) begin
      app_ok <= res_ok;
      for (int c = 0; c < NCH; c++) begin
        app_lo[c] <= res_lo[c];
        app_hi[c] <= res_hi[c];
      end
    end
  end

  assign eff_ok = sop ? res_ok : app_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign eff_lo[c] = sop ? res_lo[c] : app_lo[c];
    assign eff_hi[c] = sop ? res_hi[c] : app_hi[c];
    assign byp[c]    = !mode_on || !eff_ok || (eff_hi[c] <= eff_lo[c]);

    awb_hist_bank #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_hist (
      .clk      (clk),
      .init_clr (init_clr),
      .coll_sel (coll_sel),
      .inc_en   (inc_en),
      .inc_idx  (pix[c]),
      .scan_idx (idx),
      .scan_clr (scan_dn),
      .scan_bin (bin[c])
    );

    awb_range_find #(.PIX_W(PIX_W), .CNT_W(CNT_W), .SW(SW)) u_rng (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .step_up (scan_up),
      .step_dn (scan_dn),
      .last    (scan_last),
      .idx     (idx),
      .bin     (bin[c]),
      .clip    (clip),
      .lo      (fl_lo[c]),
      .hi      (fl_hi[c])
    );

    awb_stretch #(.PIX_W(PIX_W)) u_str (
      .clk    (clk),
      .x      (pix[c]),
      .lo     (eff_lo[c]),
      .hi     (eff_hi[c]),
      .bypass (byp[c]),
      .y      (outp[c])
    );
  end

  // Qualifier and marker pipeline, matched to the two data stages.
  logic v1, s1, e1;
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; s1 <= 1'b0; e1 <= 1'b0;
      out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0;
    end else begin
      v1 <= fire; s1 <= sop; e1 <= eop;
      out_valid <= v1; out_sof <= s1; out_eof <= e1;
    end
  end

  assign out_r = outp[0];
  assign out_g = outp[1];
  assign out_b = outp[2];
endmodule

// File: rtl/awb_top_chk.sv
module awb_top_chk #(
  parameter int PIX_W  = 8,
  parameter int MODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [MODE_W-1:0] mode,
  input logic              in_valid,
  input logic              in_sof,
  input logic              in_eof,
  input logic [PIX_W-1:0]  in_r,
  input logic [PIX_W-1:0]  in_g,
  input logic [PIX_W-1:0]  in_b,
  input logic              out_valid,
  input logic              out_sof,
  input logic              out_eof,
  input logic [PIX_W-1:0]  out_r,
  input logic [PIX_W-1:0]  out_g,
  input logic [PIX_W-1:0]  out_b,
  input logic              coll_sel
);
  AST_OUT_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid); // R2

  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2)); // R2

  AST_MARKERS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sof == $past(in_sof, 2)) && (out_eof == $past(in_eof, 2))); // R2

  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(mode, 2) != MODE_W'(1))) |->
      (out_r == $past(in_r, 2)) && (out_g == $past(in_g, 2)) && (out_b == $past(in_b, 2))); // R3

  AST_BANK_SWAP_AT_EOF: assert property (@(posedge clk) disable iff (rst)
    !$stable(coll_sel) |-> $past(in_valid && in_eof)); // R9
endmodule

bind awb_top awb_top_chk #(.PIX_W(PIX_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode),
  .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
  .in_r(in_r), .in_g(in_g), .in_b(in_b),
  .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
  .out_r(out_r), .out_g(out_g), .out_b(out_b),
  .coll_sel(coll_sel)
);

// File: tb/sim_awb_top.sv
module sim_awb_top;
  localparam int GAP = 600;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mode = 8'd0;
  logic [6:0] clip_pct = 7'd0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_r = 8'd0, in_g = 8'd0, in_b = 8'd0;
  logic       out_valid, out_sof, out_eof;
  logic [7:0] out_r, out_g, out_b;

  always #4 clk = ~clk;

  awb_top u0 (
    .clk(clk), .rst(rst), .mode(mode), .clip_pct(clip_pct),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [7:0] r, g, b;
    logic       s, e;
    int         c;
    string      tag;
  } exp_t;
  exp_t q[$];

  // Model state: levels derived from the previous frame (R5), valid flag (R1).
  int st_ok = 0;
  int st_lo[3], st_hi[3];
  int base_lv[3] = '{10, 50, 100};

  typedef struct packed {
    logic [7:0] pct, mode, ofs, rot;
  } row_t;
  localparam row_t TBL [9] = '{
    '{8'd5,   8'd1, 8'd0,  8'd0},   // first frame: no stats yet, R1
    '{8'd10,  8'd1, 8'd20, 8'd3},   // corrected with 5 percent stats, R6
    '{8'd0,   8'd1, 8'd40, 8'd50},  // corrected with 10 percent stats, R5
    '{8'd25,  8'd2, 8'd10, 8'd11},  // mode 2 passes through, R3
    '{8'd50,  8'd1, 8'd0,  8'd7},   // corrected with 25 percent stats, R8
    '{8'd3,   8'd1, 8'd56, 8'd99},  // 50 percent stats give hi<=lo, R7
    '{8'd100, 8'd1, 8'd5,  8'd1},   // corrected with 3 percent stats, R9
    '{8'd7,   8'd1, 8'd30, 8'd2},   // 100 percent stats: nothing found, R7
    '{8'd7,   8'd0, 8'd15, 8'd4}    // mode 0 passes through, R3
  };

  function automatic int exp_level(int x, int lo, int hi, int ok, int md, output string tag);
    if (md != 1)  begin tag = "R3"; return x; end
    if (ok == 0)  begin tag = "R1"; return x; end
    if (hi <= lo) begin tag = "R7"; return x; end
    tag = "R6";
    if (x <= lo) return 0;
    if (x >= hi) return 255;
    return ((x - lo) * 255) / (hi - lo);
  endfunction

  // Output monitor: compares against the expected queue (R2 timing).
  always @(negedge clk) begin
    exp_t x;
    if (out_valid) begin
      n_chk++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected output pixel, got valid=1 expected valid=0");
      end else begin
        x = q.pop_front();
        if ((cyc - x.c) != 2) begin
          n_bad++;
          $display("FAIL R2: latency got %0d expected 2", cyc - x.c);
        end else if (out_r != x.r || out_g != x.g || out_b != x.b ||
                     out_sof != x.s || out_eof != x.e) begin
          n_bad++;
          $display("FAIL %s: got rgb=%0d,%0d,%0d sof=%0b eof=%0b expected rgb=%0d,%0d,%0d sof=%0b eof=%0b",
                   x.tag, out_r, out_g, out_b, out_sof, out_eof, x.r, x.g, x.b, x.s, x.e);
        end
      end
    end else if (q.size() > 0 && cyc >= q[0].c + 2) begin
      x = q.pop_front();
      n_chk++;
      n_bad++;
      $display("FAIL R2: output missing, got valid=0 expected valid=1");
    end
  end

  task automatic send_frame(int pct_v, int md, int ofs, int rot, int flat, int npix);
    int h[3][256];
    int v[3];
    exp_t e;
    int clip, cum;
    string tg;
    for (int c = 0; c < 3; c++)
      for (int l = 0; l < 256; l++) h[c][l] = 0;
    for (int k = 0; k < npix; k++) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        v[c] = flat ? base_lv[c] + ofs : base_lv[c] + ofs + ((k + rot + 7 * c) % 100);
        h[c][v[c]]++;
      end
      in_valid = 1'b1;
      in_sof   = (k == 0);
      in_eof   = (k == npix - 1);
      mode     = 8'(md);
      // R4: only the eof pixel carries the real percentage.
      clip_pct = (k == npix - 1) ? 7'(pct_v) : 7'((pct_v + 37) % 128);
      in_r = 8'(v[0]); in_g = 8'(v[1]); in_b = 8'(v[2]);
      e.r = 8'(exp_level(v[0], st_lo[0], st_hi[0], st_ok, md, tg));
      e.g = 8'(exp_level(v[1], st_lo[1], st_hi[1], st_ok, md, tg));
      e.b = 8'(exp_level(v[2], st_lo[2], st_hi[2], st_ok, md, tg));
      e.tag = tg;
      e.s = (k == 0);
      e.e = (k == npix - 1);
      e.c = cyc;
      q.push_back(e);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    // R4/R5: levels this frame will produce for the next one.
    clip = (npix * pct_v) / 100;
    for (int c = 0; c < 3; c++) begin
      st_lo[c] = 255; cum = 0;
      for (int l = 0; l < 256; l++) begin
        cum += h[c][l];
        if (cum > clip) begin st_lo[c] = l; break; end
      end
      st_hi[c] = 0; cum = 0;
      for (int l = 255; l >= 0; l--) begin
        cum += h[c][l];
        if (cum > clip) begin st_hi[c] = l; break; end
      end
    end
    st_ok = 1;
    repeat (GAP) @(negedge clk);  // R8: idle time for evaluation
  endtask

  task automatic check_idle(string tg);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: out_valid got %b expected 0", tg, out_valid);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) begin st_lo[c] = 0; st_hi[c] = 0; end
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    repeat (300) @(negedge clk);
    check_idle("R1");

    // Table walk: each row is one ramp frame, checked against the model.
    for (int i = 0; i < 9; i++)
      send_frame(int'(TBL[i].pct), int'(TBL[i].mode), int'(TBL[i].ofs), int'(TBL[i].rot), 0, 100);

    // R9: a strongly shifted frame after another; stale counts would move the levels.
    send_frame(20, 1, 0, 9, 0, 100);
    send_frame(20, 1, 50, 33, 0, 100);
    // R7: constant frame makes hi equal lo.
    send_frame(0, 1, 20, 0, 1, 100);
    send_frame(15, 1, 20, 5, 0, 100);
    // R4: 37 pixels at 30 percent, clip count floors to 11.
    send_frame(30, 1, 12, 60, 0, 37);
    send_frame(30, 1, 12, 61, 0, 100);
    // R4: single-pixel frame (sof and eof together).
    send_frame(50, 1, 3, 0, 0, 1);
    send_frame(2, 1, 3, 0, 0, 100);
    send_frame(2, 1, 40, 77, 0, 100);

    // R1: reset in mid-run discards gathered statistics.
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    st_ok = 0;
    repeat (300) @(negedge clk);
    check_idle("R1");
    send_frame(10, 1, 0, 0, 0, 100);
    send_frame(10, 1, 0, 0, 0, 100);

    repeat (10) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: pending outputs got %0d expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule